// File: doc/BRIEF.md
# Tile Pattern Plane Generator

This block renders one background tile layer of a tile-based video controller. Each dot clock it takes the horizontal and vertical pixel counters and finds the tile under that position on a single 32x32-tile page. It reads that tile's name from an internal name table RAM and turns the name into a byte address in the pattern graphics ROM. The ROM's byte comes back as the dot's 8-bit palette index.

The tile edge length is chosen at run time among 8, 16, 32 and 64 dots. A tile name is either one byte or two adjacent bytes of the name table. The host CPU fills the name table through a plain byte write port. Tile size and name width are captured only while the vertical blank input is high, so a frame never shows a mix of modes. The output stream is three dot clocks behind the counters, and the block also outputs delayed copies of the counters and of the active flag so that downstream stages can line up with it.

Top module: `tile_plane_gen`

## Requirements
- R1: While `rst_ni` is low, `pix_o`, `transp_o`, `active_o`, `hcnt_o` and `vcnt_o` are all zero.
- R2: `active_o`, `hcnt_o` and `vcnt_o` equal `active_i`, `hcnt_i` and `vcnt_i` as sampled three clock edges earlier.
- R3: `tile_size_i` selects the tile edge: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64 dots. The tile column is `(hcnt >> log2(edge)) mod 32` and the tile row is `(vcnt >> log2(edge)) mod 32`. The cell index is `row*32 + column`. With 8-bit names the name is the byte at address `index`.
- R4: With `wide_name_i` set to 1, the name is 16 bits wide: the byte at address `2*index` is its low half and the byte at address `2*index+1` is its high half.
- R5: `rom_addr_o` equals `name*edge*edge + (vcnt mod edge)*edge + (hcnt mod edge)`, computed from the counters sampled two clock edges earlier.
- R6: When the delayed active flag is 1, `pix_o` is the `rom_data_i` byte returned for that dot's address.
- R7: When the delayed active flag is 0, `pix_o` is `border_color_i` as sampled three clock edges earlier, and `transp_o` is 0.
- R8: `transp_o` is 1 exactly when the delayed active flag is 1 and `pix_o` is 0.
- R9: `tile_size_i` and `wide_name_i` are captured on every clock edge that samples `vblank_i` high. Changes to them while `vblank_i` is low have no effect on the output.
- R10: A clock edge that samples `nt_we_i` high stores `nt_wdata_i` at byte address `nt_addr_i` of the 4 KB name table. Dots fetched on later cycles see the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hcnt_i | input | H_W | Horizontal pixel counter |
| vcnt_i | input | V_W | Vertical pixel counter |
| active_i | input | 1 | Dot lies in the active display area |
| vblank_i | input | 1 | Vertical blank; the mode is captured while high |
| tile_size_i | input | 2 | Tile edge select (0:8, 1:16, 2:32, 3:64) |
| wide_name_i | input | 1 | 1: 16-bit names, 0: 8-bit names |
| border_color_i | input | PIX_W | Palette index shown outside the active area |
| nt_we_i | input | 1 | Name table write strobe |
| nt_addr_i | input | NT_AW | Name table byte address |
| nt_wdata_i | input | 8 | Name table write byte |
| rom_addr_o | output | ROM_AW | Pattern ROM byte address |
| rom_data_i | input | PIX_W | Pattern ROM byte, valid in the same cycle as the address |
| pix_o | output | PIX_W | Palette index for the dot |
| transp_o | output | 1 | Dot is transparent |
| active_o | output | 1 | Delayed active flag |
| hcnt_o | output | H_W | Delayed horizontal counter |
| vcnt_o | output | V_W | Delayed vertical counter |

## Verification
The latency assertions assume that reset is released cleanly and that the counters and the active flag are sampled on every edge after that. No gaps or stalls are allowed. The mode-hold assertion assumes that mode inputs may change at any time, while only vblank controls capture. The stimulus therefore drives random tile sizes and name widths in the middle of scan lines, with vblank low. The ROM is taken to answer combinationally. The bench never writes the name table in a cycle whose read it checks: the table is loaded before checking starts. Counters are driven both in raster order and at random, so that every tile size reaches distant pages, rows and columns.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    TS_8  = 2'd0,
    TS_16 = 2'd1,
    TS_32 = 2'd2,
    TS_64 = 2'd3
  } tile_size_e;

  typedef struct packed {
    tile_size_e size;
    logic       wide;
  } plane_mode_t;

  localparam int TILE_LG_MIN = 3;
  localparam int TILE_LG_MAX = 6;
  localparam int NAME_W      = 16;
endpackage

// File: rtl/tpg_mode_latch.sv
module tpg_mode_latch
  import tpg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        vblank_i,
  input  plane_mode_t mode_i,
  output plane_mode_t mode_o
);
  plane_mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= '{size: TS_8, wide: 1'b0};
    else if (vblank_i) mode_q <= mode_i;
  end

  assign mode_o = mode_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_i |=> $stable(mode_o)); // R9
endmodule

// File: rtl/tpg_name_ram.sv
module tpg_name_ram
  import tpg_pkg::*;
#(
  parameter int NT_BYTES = 4096,
  parameter int IDX_W    = 10,
  localparam int NT_AW   = $clog2(NT_BYTES)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [NT_AW-1:0]  waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wide_i,
  output logic [NAME_W-1:0] name_o
);
  localparam int BANK_AW    = NT_AW - 1;
  localparam int BANK_DEPTH = NT_BYTES / 2;

  // even bytes in bank 0, odd in bank 1: a 16-bit name is one word of each
  logic [BANK_AW-1:0] raddr;
  logic               sel_q;
  logic               wide_q;

  assign raddr = wide_i ? BANK_AW'(idx_i) : BANK_AW'(idx_i >> 1);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [BANK_DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i[0] == 1'(b))) mem[waddr_i[NT_AW-1:1]] <= wdata_i;
      q <= mem[raddr];
    end
  end

  always_ff @(posedge clk_i) begin
    sel_q  <= idx_i[0];
    wide_q <= wide_i;
  end

  assign name_o = wide_q ? {g_bank[1].q, g_bank[0].q}
                         : {8'h00, (sel_q ? g_bank[1].q : g_bank[0].q)};
endmodule

// File: rtl/tpg_addr_gen.sv
module tpg_addr_gen
  import tpg_pkg::*;
#(
  parameter int ROM_AW = 28
) (
  input  logic [NAME_W-1:0]      name_i,
  input  tile_size_e             size_i,
  input  logic [TILE_LG_MAX-1:0] row_i,
  input  logic [TILE_LG_MAX-1:0] col_i,
  output logic [ROM_AW-1:0]      addr_o
);
  logic [2:0] lg;
  logic [3:0] lg2;

  assign lg  = 3'(TILE_LG_MIN) + {1'b0, size_i};
  assign lg2 = {lg, 1'b0};
  // name * edge^2 + row * edge + col
  assign addr_o = (ROM_AW'(name_i) << lg2) + (ROM_AW'(row_i) << lg) + ROM_AW'(col_i);
endmodule

// File: rtl/tile_plane_gen.sv
module tile_plane_gen
  import tpg_pkg::*;
#(
  parameter int H_W      = 9,
  parameter int V_W      = 9,
  parameter int NT_BYTES = 4096,
  parameter int PAGE_LG  = 5,
  parameter int PIX_W    = 8,
  parameter int ROM_AW   = 28,
  localparam int NT_AW   = $clog2(NT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [H_W-1:0]    hcnt_i,
  input  logic [V_W-1:0]    vcnt_i,
  input  logic              active_i,
  input  logic              vblank_i,
  input  logic [1:0]        tile_size_i,
  input  logic              wide_name_i,
  input  logic [PIX_W-1:0]  border_color_i,
  input  logic              nt_we_i,
  input  logic [NT_AW-1:0]  nt_addr_i,
  input  logic [7:0]        nt_wdata_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [PIX_W-1:0]  rom_data_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              transp_o,
  output logic              active_o,
  output logic [H_W-1:0]    hcnt_o,
  output logic [V_W-1:0]    vcnt_o
);
  localparam int IDX_W = 2 * PAGE_LG;
  localparam int TL_W  = TILE_LG_MAX;

  plane_mode_t mode_in, mode_q;
  assign mode_in = '{size: tile_size_e'(tile_size_i), wide: wide_name_i};

  tpg_mode_latch u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vblank_i(vblank_i),
    .mode_i  (mode_in),
    .mode_o  (mode_q)
  );

  // stage 0: tile cell and in-tile position
  logic [2:0]         lg_s0;
  logic [TL_W-1:0]    msk_s0, row_s0, col_s0;
  logic [H_W-1:0]     hsh_s0;
  logic [V_W-1:0]     vsh_s0;
  logic [IDX_W-1:0]   idx_s0;

  assign lg_s0  = 3'(TILE_LG_MIN) + {1'b0, mode_q.size};
  assign msk_s0 = (TL_W'(1) << lg_s0) - TL_W'(1);
  assign hsh_s0 = hcnt_i >> lg_s0;
  assign vsh_s0 = vcnt_i >> lg_s0;
  assign idx_s0 = {vsh_s0[PAGE_LG-1:0], hsh_s0[PAGE_LG-1:0]};
  assign row_s0 = vcnt_i[TL_W-1:0] & msk_s0;
  assign col_s0 = hcnt_i[TL_W-1:0] & msk_s0;

  logic [NAME_W-1:0] name_s1;

  tpg_name_ram #(.NT_BYTES(NT_BYTES), .IDX_W(IDX_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (nt_we_i),
    .waddr_i(nt_addr_i),
    .wdata_i(nt_wdata_i),
    .idx_i  (idx_s0),
    .wide_i (mode_q.wide),
    .name_o (name_s1)
  );

  // stage 1
  tile_size_e       size_s1;
  logic [TL_W-1:0]  row_s1, col_s1;
  logic             act_s1;
  logic [PIX_W-1:0] bord_s1;
  logic [H_W-1:0]   h_s1;
  logic [V_W-1:0]   v_s1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_s1 <= TS_8;
      row_s1  <= '0;
      col_s1  <= '0;
      act_s1  <= 1'b0;
      bord_s1 <= '0;
      h_s1    <= '0;
      v_s1    <= '0;
    end else begin
      size_s1 <= mode_q.size;
      row_s1  <= row_s0;
      col_s1  <= col_s0;
      act_s1  <= active_i;
      bord_s1 <= border_color_i;
      h_s1    <= hcnt_i;
      v_s1    <= vcnt_i;
    end
  end

  logic [ROM_AW-1:0] addr_s1;

  tpg_addr_gen #(.ROM_AW(ROM_AW)) u_addr (
    .name_i(name_s1),
    .size_i(size_s1),
    .row_i (row_s1),
    .col_i (col_s1),
    .addr_o(addr_s1)
  );

  // stage 2: ROM address out, data back in the same cycle
  logic [ROM_AW-1:0] addr_s2;
  logic              act_s2;
  logic [PIX_W-1:0]  bord_s2;
  logic [H_W-1:0]    h_s2;
  logic [V_W-1:0]    v_s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_s2 <= '0;
      act_s2  <= 1'b0;
      bord_s2 <= '0;
      h_s2    <= '0;
      v_s2    <= '0;
    end else begin
      addr_s2 <= addr_s1;
      act_s2  <= act_s1;
      bord_s2 <= bord_s1;
      h_s2    <= h_s1;
      v_s2    <= v_s1;
    end
  end

  assign rom_addr_o = addr_s2;

  // stage 3: output dot
  logic [PIX_W-1:0] pix_s3;
  logic             tr_s3, act_s3;
  logic [H_W-1:0]   h_s3;
  logic [V_W-1:0]   v_s3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_s3 <= '0;
      tr_s3  <= 1'b0;
      act_s3 <= 1'b0;
      h_s3   <= '0;
      v_s3   <= '0;
    end else begin
      pix_s3 <= act_s2 ? rom_data_i : bord_s2;
      tr_s3  <= act_s2 && (rom_data_i == '0);
      act_s3 <= act_s2;
      h_s3   <= h_s2;
      v_s3   <= v_s2;
    end
  end

  assign pix_o    = pix_s3;
  assign transp_o = tr_s3;
  assign active_o = act_s3;
  assign hcnt_o   = h_s3;
  assign vcnt_o   = v_s3;

  // cycles since reset, for latency checks only
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= 2'd0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  AST_LAT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (active_o == $past(active_i, 3))); // R2
  AST_LAT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (hcnt_o == $past(hcnt_i, 3) && vcnt_o == $past(vcnt_i, 3))); // R2
  AST_BORDER_OPAQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !transp_o); // R7
  AST_TRANSP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transp_o |-> (pix_o == '0 && active_o)); // R8
endmodule

// File: tb/tile_plane_gen_tb_top.sv
module tile_plane_gen_tb_top;
  localparam int H_W = 9, V_W = 9, ROM_AW = 28;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [H_W-1:0]    hcnt, hcnt_d;
  logic [V_W-1:0]    vcnt, vcnt_d;
  logic              act, act_d, vblank, wide, tr, we;
  logic [1:0]        tsize;
  logic [7:0]        bord, wdat, pix, rom_data;
  logic [11:0]       waddr;
  logic [ROM_AW-1:0] rom_addr;

  tile_plane_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hcnt_i(hcnt), .vcnt_i(vcnt), .active_i(act),
    .vblank_i(vblank), .tile_size_i(tsize), .wide_name_i(wide), .border_color_i(bord),
    .nt_we_i(we), .nt_addr_i(waddr), .nt_wdata_i(wdat), .rom_addr_o(rom_addr),
    .rom_data_i(rom_data), .pix_o(pix), .transp_o(tr), .active_o(act_d),
    .hcnt_o(hcnt_d), .vcnt_o(vcnt_d)
  );

  function automatic logic [7:0] rom_f(input logic [27:0] a);
    logic [7:0] r;
    if (a[3:0] == 4'd5) return 8'h00;
    r = a[7:0] ^ a[15:8] ^ a[23:16] ^ {a[27:24], 4'h3};
    if (r == 8'h00) r = 8'h5A;
    return r;
  endfunction

  assign rom_data = rom_f(rom_addr);

  logic [7:0]  nt_m [4096];
  int          m_size = 0;
  bit          m_wide = 1'b0;
  logic [7:0]  e_pix  [8];
  bit          e_tr   [8];
  bit          e_act  [8];
  bit          e_val  [8];
  logic [8:0]  e_h    [8];
  logic [8:0]  e_v    [8];
  logic [27:0] e_addr [8];
  int vectors = 0, errors = 0, cyc = 0;

  task automatic check_out();
    int k;
    if (cyc >= 2 && e_val[(cyc - 2) % 8]) begin
      k = (cyc - 2) % 8;
      vectors++;
      if (rom_addr !== e_addr[k]) begin
        errors++;
        $display("FAIL R5 (R3/R4 name fetch) cyc=%0d rom_addr act=%0h exp=%0h", cyc, rom_addr, e_addr[k]);
      end
    end
    if (cyc >= 3 && e_val[(cyc - 3) % 8]) begin
      k = (cyc - 3) % 8;
      vectors++;
      if (pix !== e_pix[k]) begin
        errors++;
        if (e_act[k]) $display("FAIL R6 cyc=%0d pix act=%0h exp=%0h", cyc, pix, e_pix[k]);
        else          $display("FAIL R7 cyc=%0d border act=%0h exp=%0h", cyc, pix, e_pix[k]);
      end
      vectors++;
      if (tr !== e_tr[k]) begin
        errors++;
        $display("FAIL R8 cyc=%0d transp act=%0b exp=%0b", cyc, tr, e_tr[k]);
      end
      vectors++;
      if (act_d !== e_act[k] || hcnt_d !== e_h[k] || vcnt_d !== e_v[k]) begin
        errors++;
        $display("FAIL R2 cyc=%0d act/h/v act=%0b/%0d/%0d exp=%0b/%0d/%0d", cyc,
                 act_d, hcnt_d, vcnt_d, e_act[k], e_h[k], e_v[k]);
      end
    end
  endtask

  task automatic step(input int h, input int v, input bit a, input bit vb, input int ts,
                      input bit wd, input int bd, input bit w, input int wa, input int wv,
                      input bit val);
    int k, sz, lg, idx, name;
    longint ad;
    @(negedge clk);
    check_out();
    hcnt = 9'(h); vcnt = 9'(v); act = a; vblank = vb; tsize = 2'(ts); wide = wd;
    bord = 8'(bd); we = w; waddr = 12'(wa); wdat = 8'(wv);
    k   = cyc % 8;
    sz  = 8 << m_size;
    lg  = 3 + m_size;
    idx = ((v >> lg) % 32) * 32 + ((h >> lg) % 32);
    name = m_wide ? (int'(nt_m[2 * idx]) + 256 * int'(nt_m[2 * idx + 1])) : int'(nt_m[idx]);
    ad  = longint'(name) * sz * sz + longint'(v % sz) * sz + longint'(h % sz);
    e_addr[k] = ad[27:0];
    e_act[k]  = a;
    e_pix[k]  = a ? rom_f(ad[27:0]) : 8'(bd);
    e_tr[k]   = a && (rom_f(ad[27:0]) == 8'h00);
    e_h[k]    = 9'(h);
    e_v[k]    = 9'(v);
    e_val[k]  = val;
    if (vb) begin  // R9: capture only in vblank
      m_size = ts;
      m_wide = wd;
    end
    if (w) nt_m[wa] = 8'(wv);  // R10
    cyc++;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int h, v;
    bit a;
    rst_n = 1'b0; hcnt = '0; vcnt = '0; act = 1'b1; vblank = 1'b0; tsize = 2'd2;
    wide = 1'b1; bord = 8'h77; we = 1'b0; waddr = '0; wdat = '0;
    for (int i = 0; i < 8; i++) e_val[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    vectors++;
    if (pix !== 8'h00 || tr !== 1'b0 || act_d !== 1'b0 || hcnt_d !== '0 || vcnt_d !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs act=%0h/%0b/%0b/%0d/%0d exp=0", pix, tr, act_d, hcnt_d, vcnt_d);
    end
    rst_n = 1'b1;
    act = 1'b0;
    // R10 load name table through the write port
    for (int i = 0; i < 4096; i++)
      step(0, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, i, (i % 11 == 0) ? 0 : ((i * 37) ^ (i >> 4)) & 255, 1'b0);
    for (int f = 0; f < 12; f++) begin
      // R3 tile sizes, R4 name width
      step(0, 0, 1'b0, 1'b1, f % 4, (f / 4) % 2 == 1, 16 + f, 1'b0, 0, 0, 1'b1);
      for (int n = 0; n < 1500; n++) begin
        if (f % 2 == 0) begin
          h = $urandom % 512; v = $urandom % 512; a = ($urandom % 8) != 0;
        end else begin
          h = n % 320; v = (n / 320) * 37 + f * 11; a = (h >= 16) && (h < 300);
        end
        // R9: mode inputs toggled outside vblank must be ignored
        step(h, v % 512, a, 1'b0, $urandom % 4, $urandom % 2 == 1, $urandom % 256,
             1'b0, 0, 0, 1'b1);
      end
    end
    repeat (4) step(0, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule